// File: doc/BRIEF.md
# Serial Flash Command Front End

This block is the command side of a serial NOR flash device model. It watches an active-low chip select, a serial clock and a single data-in lane, all sampled by a faster system clock. It takes the first eight bits of each transaction as the opcode. It holds the device status byte and the flag byte, and returns them, or a fixed identification string, on a single data-out lane. Input bits are captured on serial clock rising edges. Output bits change on falling edges, most significant bit first.

Write-type opcodes are screened when the opcode byte completes. They act only when the transaction ends: on release of chip select the block issues a one-cycle commit strobe and the opcode to the program and erase logic downstream. It then sets write-in-progress, drops write-enable and runs a busy timer whose length depends on the operation. When the timer expires, both low status bits clear. The memory array and multi-lane modes belong to other blocks.

Top module: `flash_cmd_frontend`

## Requirements
- R1: After reset, a status read returns 0x1C and a flag read returns 0xA5, miso is 0 and commit_stb is 0.
- R2: Opcode 0x06 sets the write-enable bit (status bit 1). Opcode 0x04 clears it.
- R3: Write-type opcodes (0x01, 0x02, 0x20, 0x32, 0x42, 0xC7, 0xD8) are accepted only when status bit 1 is 1 and status bit 0 is 0. A rejected one produces no commit and leaves the status unchanged.
- R4: Releasing chip select after an accepted write-type transaction gives exactly one commit_stb cycle carrying that opcode. The status then shows bit 0 set and bit 1 clear.
- R5: The busy period lasts the parameter-set time for the operation: 0x01 uses T_WRSR; 0x02, 0x32 and 0x42 use T_PROG; 0x20 uses T_SUB; 0xD8 uses T_SECT; 0xC7 uses T_BULK. When it ends, status bits 0 and 1 are both 0.
- R6: Opcode 0x05 returns the current status on every byte after the opcode. Opcode 0x70 does the same with the flag byte.
- R7: Opcode 0x50 ANDs the flag byte with 0x9F when chip select rises.
- R8: Opcode 0x01 followed by one data byte replaces status bits 6..2 with the data's bits 6..2. Bits 7, 1 and 0 are not taken from the data.
- R9: Opcodes 0x9E and 0x9F return 20 identification bytes: 0x20, 0xBA, 0x18, 0x10, then 0xFE counting down by one to 0xEF. Any later byte reads 0x00.
- R10: Opcode 0x03 and any opcode not listed here send the transaction to an invalid state. Further bytes have no effect, all returned bytes are 0x00, and there is no commit.
- R11: While chip select is high, miso is 0 and the bit and byte counters are cleared. A partial opcode aborted by chip select has no effect and does not shift the alignment of the next transaction.
- R12: Opcode 0x01 released before its data byte has completed produces no commit and no status change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock, idles low |
| mosi | input | 1 | Serial data in, sampled on sclk rising edges |
| miso | output | 1 | Serial data out, changes after sclk falling edges |
| commit_stb | output | 1 | One-cycle pulse when an accepted write-type transaction ends |
| commit_op | output | 8 | Opcode that belongs to commit_stb |

## Verification
Every write-type opcode is run twice: with write-enable clear, where no commit must appear, and with it set, where a commit must appear. The second case also runs while a previous operation is still busy, which separates a check of bit 1 alone from a check of both low bits. A status write with data 0xFF and then 0x8B shows which status bits the data may replace. Busy periods are timed by polling the status from the commit until it clears and comparing against each operation's parameter. The identification stream is read past its end. Aborted partial opcodes, invalid opcodes carrying a write-enable byte, and an empty status write check that misaligned or discarded input changes nothing.

// File: rtl/flash_fe_pkg.sv
package flash_fe_pkg;
  localparam logic [7:0] OP_STAT_WR  = 8'h01;
  localparam logic [7:0] OP_PROG     = 8'h02;
  localparam logic [7:0] OP_SLOW_RD  = 8'h03;
  localparam logic [7:0] OP_WE_OFF   = 8'h04;
  localparam logic [7:0] OP_STAT_RD  = 8'h05;
  localparam logic [7:0] OP_WE_ON    = 8'h06;
  localparam logic [7:0] OP_ERASE4K  = 8'h20;
  localparam logic [7:0] OP_PROG4    = 8'h32;
  localparam logic [7:0] OP_PROG_OTP = 8'h42;
  localparam logic [7:0] OP_FLAG_CLR = 8'h50;
  localparam logic [7:0] OP_FLAG_RD  = 8'h70;
  localparam logic [7:0] OP_ID_A     = 8'h9E;
  localparam logic [7:0] OP_ID_B     = 8'h9F;
  localparam logic [7:0] OP_ERASE_ALL = 8'hC7;
  localparam logic [7:0] OP_ERASE64K = 8'hD8;

  localparam logic [7:0] STATUS_INIT = 8'h1C;
  localparam logic [7:0] FLAG_INIT   = 8'hA5;
  localparam logic [7:0] FLAG_KEEP   = 8'h9F;
  localparam int unsigned ID_BYTES   = 20;

  typedef enum logic [2:0] {
    DS_IDLE, DS_STAT_OUT, DS_FLAG_OUT, DS_ID_OUT,
    DS_STAT_IN, DS_WRITE_OP, DS_FLAG_CLR, DS_INVALID
  } dec_state_t;

  function automatic logic [7:0] id_byte(input int unsigned idx);
    logic [7:0] b;
    case (idx)
      0: b = 8'h20;
      1: b = 8'hBA;
      2: b = 8'h18;
      3: b = 8'h10;
      default: b = (idx < ID_BYTES) ? 8'(32'hFE - (idx - 4)) : 8'h00;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/spi_bit_engine.sv
module spi_bit_engine #(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             mosi,
  input  logic             load_en,
  input  logic [7:0]       load_data,
  output logic             miso,
  output logic             cs_rise,
  output logic             byte_valid,
  output logic [7:0]       byte_data,
  output logic [IDX_W-1:0] byte_idx
);
  localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};

  logic             sclk_q, cs_q;
  logic [2:0]       bit_pos;
  logic [6:0]       in_sh;
  logic [7:0]       out_sh;
  logic [IDX_W-1:0] idx_q;
  logic             rise, fall;

  assign rise    = !cs_n && sclk && !sclk_q;
  assign fall    = !cs_n && !sclk && sclk_q;
  assign cs_rise = cs_n && !cs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q     <= 1'b0;
      cs_q       <= 1'b1;
      bit_pos    <= '0;
      in_sh      <= '0;
      out_sh     <= '0;
      idx_q      <= '0;
      miso       <= 1'b0;
      byte_valid <= 1'b0;
      byte_data  <= '0;
      byte_idx   <= '0;
    end else begin
      sclk_q     <= sclk;
      cs_q       <= cs_n;
      byte_valid <= 1'b0;
      if (cs_n) begin
        bit_pos <= '0;
        in_sh   <= '0;
        out_sh  <= '0;
        idx_q   <= '0;
        miso    <= 1'b0;
      end else begin
        if (rise) begin
          in_sh   <= {in_sh[5:0], mosi};
          bit_pos <= bit_pos + 3'd1;
          if (bit_pos == 3'd7) begin
            byte_valid <= 1'b1;
            byte_data  <= {in_sh, mosi};
            byte_idx   <= idx_q;
            if (idx_q != IDX_MAX) idx_q <= idx_q + 1'b1;
          end
        end
        if (fall && bit_pos != 3'd0) out_sh <= {out_sh[6:0], 1'b0};
        if (load_en) out_sh <= load_data;
        miso <= out_sh[7];
      end
    end
  end
endmodule

// File: rtl/flash_opcode_fsm.sv
module flash_opcode_fsm
  import flash_fe_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             cs_rise,
  input  logic             byte_valid,
  input  logic [7:0]       byte_data,
  input  logic [IDX_W-1:0] byte_idx,
  input  logic [7:0]       status,
  input  logic [7:0]       flag,
  output logic [7:0]       load_data,
  output logic             wel_set,
  output logic             wel_clr,
  output logic             clr_flag,
  output logic             commit_stb,
  output logic [7:0]       commit_op,
  output logic [4:0]       stat_field
);
  dec_state_t state;
  logic [7:0] op_q;
  logic       have_data;
  logic       write_ok;

  assign write_ok = (status[1:0] == 2'b10);

  always_comb begin
    load_data = 8'h00;
    if (byte_idx == '0) begin
      case (byte_data)
        OP_STAT_RD:      load_data = status;
        OP_FLAG_RD:      load_data = flag;
        OP_ID_A, OP_ID_B: load_data = id_byte(0);
        default:         load_data = 8'h00;
      endcase
    end else begin
      case (state)
        DS_STAT_OUT: load_data = status;
        DS_FLAG_OUT: load_data = flag;
        DS_ID_OUT:   load_data = id_byte(32'(byte_idx));
        default:     load_data = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= DS_IDLE;
      op_q       <= '0;
      have_data  <= 1'b0;
      wel_set    <= 1'b0;
      wel_clr    <= 1'b0;
      clr_flag   <= 1'b0;
      commit_stb <= 1'b0;
      commit_op  <= '0;
      stat_field <= '0;
    end else begin
      wel_set    <= 1'b0;
      wel_clr    <= 1'b0;
      clr_flag   <= 1'b0;
      commit_stb <= 1'b0;
      if (cs_rise) begin
        case (state)
          DS_WRITE_OP: begin commit_stb <= 1'b1; commit_op <= op_q; end
          DS_STAT_IN:  if (have_data) begin commit_stb <= 1'b1; commit_op <= op_q; end
          DS_FLAG_CLR: clr_flag <= 1'b1;
          default: ;
        endcase
      end
      if (cs_n) begin
        state     <= DS_IDLE;
        have_data <= 1'b0;
      end else if (byte_valid) begin
        if (byte_idx == '0) begin
          op_q <= byte_data;
          case (byte_data)
            OP_WE_ON:    wel_set <= 1'b1;
            OP_WE_OFF:   wel_clr <= 1'b1;
            OP_STAT_RD:  state <= DS_STAT_OUT;
            OP_FLAG_RD:  state <= DS_FLAG_OUT;
            OP_ID_A, OP_ID_B: state <= DS_ID_OUT;
            OP_FLAG_CLR: state <= DS_FLAG_CLR;
            OP_STAT_WR:  state <= write_ok ? DS_STAT_IN : DS_INVALID;
            OP_PROG, OP_ERASE4K, OP_PROG4, OP_PROG_OTP, OP_ERASE_ALL, OP_ERASE64K:
                         state <= write_ok ? DS_WRITE_OP : DS_INVALID;
            default:     state <= DS_INVALID;
          endcase
        end else if (state == DS_STAT_IN && !have_data) begin
          stat_field <= byte_data[6:2];
          have_data  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/flash_status_unit.sv
module flash_status_unit
  import flash_fe_pkg::*;
#(
  parameter int BUSY_W = 16,
  parameter int T_WRSR = 600,
  parameter int T_PROG = 800,
  parameter int T_SUB  = 900,
  parameter int T_SECT = 1000,
  parameter int T_BULK = 1200
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wel_set,
  input  logic       wel_clr,
  input  logic       clr_flag,
  input  logic       commit_stb,
  input  logic [7:0] commit_op,
  input  logic [4:0] stat_field,
  output logic [7:0] status,
  output logic [7:0] flag
);
  logic [BUSY_W-1:0] busy_cnt;
  logic [BUSY_W-1:0] busy_load;

  always_comb begin
    case (commit_op)
      OP_STAT_WR:   busy_load = BUSY_W'(T_WRSR);
      OP_ERASE4K:   busy_load = BUSY_W'(T_SUB);
      OP_ERASE64K:  busy_load = BUSY_W'(T_SECT);
      OP_ERASE_ALL: busy_load = BUSY_W'(T_BULK);
      default:      busy_load = BUSY_W'(T_PROG);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status   <= STATUS_INIT;
      flag     <= FLAG_INIT;
      busy_cnt <= '0;
    end else begin
      if (wel_set) status[1] <= 1'b1;
      if (wel_clr) status[1] <= 1'b0;
      if (clr_flag) flag <= flag & FLAG_KEEP;
      if (busy_cnt != '0) begin
        busy_cnt <= busy_cnt - 1'b1;
        if (busy_cnt == BUSY_W'(1)) status[1:0] <= 2'b00;
      end
      if (commit_stb) begin
        status[0] <= 1'b1;
        status[1] <= 1'b0;
        busy_cnt  <= busy_load;
        if (commit_op == OP_STAT_WR) status[6:2] <= stat_field;
      end
    end
  end
endmodule

// File: rtl/flash_cmd_frontend.sv
module flash_cmd_frontend #(
  parameter int IDX_W  = 5,
  parameter int BUSY_W = 16,
  parameter int T_WRSR = 600,
  parameter int T_PROG = 800,
  parameter int T_SUB  = 900,
  parameter int T_SECT = 1000,
  parameter int T_BULK = 1200
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n,
  input  logic       sclk,
  input  logic       mosi,
  output logic       miso,
  output logic       commit_stb,
  output logic [7:0] commit_op
);
  logic             cs_rise, byte_valid;
  logic [7:0]       byte_data, load_data;
  logic [IDX_W-1:0] byte_idx;
  logic [7:0]       status_q, flag_q;
  logic             wel_set, wel_clr, clr_flag;
  logic [4:0]       stat_field;

  spi_bit_engine #(.IDX_W(IDX_W)) u_bits (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .load_en(byte_valid), .load_data(load_data), .miso(miso),
    .cs_rise(cs_rise), .byte_valid(byte_valid), .byte_data(byte_data),
    .byte_idx(byte_idx)
  );

  flash_opcode_fsm #(.IDX_W(IDX_W)) u_fsm (
    .clk(clk), .rst(rst), .cs_n(cs_n), .cs_rise(cs_rise),
    .byte_valid(byte_valid), .byte_data(byte_data), .byte_idx(byte_idx),
    .status(status_q), .flag(flag_q), .load_data(load_data),
    .wel_set(wel_set), .wel_clr(wel_clr), .clr_flag(clr_flag),
    .commit_stb(commit_stb), .commit_op(commit_op), .stat_field(stat_field)
  );

  flash_status_unit #(
    .BUSY_W(BUSY_W), .T_WRSR(T_WRSR), .T_PROG(T_PROG),
    .T_SUB(T_SUB), .T_SECT(T_SECT), .T_BULK(T_BULK)
  ) u_stat (
    .clk(clk), .rst(rst), .wel_set(wel_set), .wel_clr(wel_clr),
    .clr_flag(clr_flag), .commit_stb(commit_stb), .commit_op(commit_op),
    .stat_field(stat_field), .status(status_q), .flag(flag_q)
  );
endmodule

// File: rtl/flash_cmd_frontend_chk.sv
module flash_cmd_frontend_chk (
  input logic       clk,
  input logic       rst,
  input logic       cs_n,
  input logic       miso,
  input logic       commit_stb,
  input logic [7:0] commit_op,
  input logic [1:0] st_low,
  input logic [7:0] flag,
  input logic       wel_set,
  input logic       clr_flag
);
  assert_commit_single_R4: assert property (@(posedge clk) disable iff (rst)
    commit_stb |=> !commit_stb);

  assert_commit_at_release_R4: assert property (@(posedge clk) disable iff (rst)
    commit_stb |-> ($past(cs_n) && !$past(cs_n, 2)));

  assert_commit_write_type_R3: assert property (@(posedge clk) disable iff (rst)
    commit_stb |-> (commit_op inside {8'h01, 8'h02, 8'h20, 8'h32, 8'h42, 8'hC7, 8'hD8}));

  assert_wip_from_commit_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(st_low[0]) |-> $past(commit_stb));

  assert_busy_end_clears_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(st_low[0]) |-> !st_low[1]);

  assert_wel_from_cmd_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(st_low[1]) |-> $past(wel_set));

  assert_flag_from_clear_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(flag) |-> $past(clr_flag));

  assert_miso_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    $past(cs_n) |-> !miso);
endmodule

bind flash_cmd_frontend flash_cmd_frontend_chk u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .miso(miso),
  .commit_stb(commit_stb), .commit_op(commit_op),
  .st_low(status_q[1:0]), .flag(flag_q),
  .wel_set(wel_set), .clr_flag(clr_flag)
);

// File: tb/flash_cmd_frontend_test.sv
module flash_cmd_frontend_test;
  localparam int HP     = 4;
  localparam int T_WRSR = 600;
  localparam int T_PROG = 800;
  localparam int T_SUB  = 900;
  localparam int T_SECT = 1000;
  localparam int T_BULK = 1200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic mosi = 1'b0;
  logic miso, commit_stb;
  logic [7:0] commit_op;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int commit_cnt = 0;
  int commit_cyc = 0;
  logic [7:0] last_op = 8'h00;
  logic [7:0] rbuf [0:31];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  flash_cmd_frontend #(
    .T_WRSR(T_WRSR), .T_PROG(T_PROG), .T_SUB(T_SUB),
    .T_SECT(T_SECT), .T_BULK(T_BULK)
  ) uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .miso(miso), .commit_stb(commit_stb), .commit_op(commit_op)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst && commit_stb) begin
      commit_cnt = commit_cnt + 1;
      last_op    = commit_op;
      commit_cyc = cyc;
    end
  end

  always @(negedge clk) begin
    if (!done && cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog actual=%0d expected<=150000 cycles", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic xbits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 7; i > 7 - nb; i--) begin
      mosi = tx[i];
      repeat (HP) @(negedge clk);
      rx[i] = miso;
      sclk = 1'b1;
      repeat (HP) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic cs_lo();
    @(negedge clk);
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic cs_hi();
    @(negedge clk);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic txn(input logic [7:0] op, input int nextra, input logic [7:0] fill);
    logic [7:0] d;
    cs_lo();
    xbits(op, 8, d);
    for (int i = 0; i < nextra; i++) xbits(fill, 8, rbuf[i]);
    cs_hi();
  endtask

  task automatic rd_status(output logic [7:0] s);
    txn(8'h05, 1, 8'h00);
    s = rbuf[0];
  endtask

  function automatic int busy_of(input logic [7:0] op);
    case (op)
      8'h01: return T_WRSR;
      8'h20: return T_SUB;
      8'hD8: return T_SECT;
      8'hC7: return T_BULK;
      default: return T_PROG;
    endcase
  endfunction

  function automatic logic [7:0] exp_id(input int i);
    case (i)
      0: return 8'h20;
      1: return 8'hBA;
      2: return 8'h18;
      3: return 8'h10;
      default: return (i < 20) ? 8'(254 - (i - 4)) : 8'h00;
    endcase
  endfunction

  task automatic wait_idle(input int tmin, input logic [7:0] exp_final, input string what);
    logic [7:0] s;
    int polls = 0;
    int el;
    rd_status(s);
    chk("R4", {what, " busy after commit"}, int'(s[1:0]), 1);
    while (s[0] && polls < 40) begin
      rd_status(s);
      polls++;
    end
    el = cyc - commit_cyc;
    chk("R5", {what, " busy not too short"}, int'(el >= tmin), 1);
    chk("R5", {what, " busy not too long"}, int'(el <= tmin + 400), 1);
    chk("R5", {what, " status after busy"}, int'(s), int'(exp_final));
  endtask

  initial begin
    logic [7:0] s;
    logic [7:0] wops [0:5];
    int c0;
    wops[0] = 8'h02; wops[1] = 8'h20; wops[2] = 8'h32;
    wops[3] = 8'h42; wops[4] = 8'hC7; wops[5] = 8'hD8;

    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "miso after reset", int'(miso), 0);
    chk("R1", "commit_stb after reset", int'(commit_stb), 0);

    // R1 R6: status and flag repeat on every byte
    txn(8'h05, 3, 8'h00);
    for (int i = 0; i < 3; i++) chk("R1", "status byte", int'(rbuf[i]), 8'h1C);
    txn(8'h70, 3, 8'hFF);
    for (int i = 0; i < 3; i++) chk("R6", "flag byte", int'(rbuf[i]), 8'hA5);

    // R9: identification stream past its end
    txn(8'h9F, 24, 8'h00);
    for (int i = 0; i < 24; i++) chk("R9", "id 9F byte", int'(rbuf[i]), int'(exp_id(i)));
    txn(8'h9E, 4, 8'h00);
    for (int i = 0; i < 4; i++) chk("R9", "id 9E byte", int'(rbuf[i]), int'(exp_id(i)));

    // R3: write-type opcodes without write-enable
    c0 = commit_cnt;
    txn(8'h01, 1, 8'hFF);
    for (int k = 0; k < 6; k++) txn(wops[k], 3, 8'h00);
    chk("R3", "commits without write-enable", commit_cnt - c0, 0);
    rd_status(s);
    chk("R3", "status after rejected writes", int'(s), 8'h1C);

    // R2: write-enable on and off
    txn(8'h06, 0, 8'h00);
    rd_status(s);
    chk("R2", "status after 06", int'(s), 8'h1E);
    txn(8'h04, 0, 8'h00);
    rd_status(s);
    chk("R2", "status after 04", int'(s), 8'h1C);

    // R12: status write released before the data byte
    txn(8'h06, 0, 8'h00);
    c0 = commit_cnt;
    txn(8'h01, 0, 8'h00);
    chk("R12", "commit without data byte", commit_cnt - c0, 0);
    rd_status(s);
    chk("R12", "status after empty write", int'(s), 8'h1E);

    // R8 R4 R5 R3: status write 0xFF, then a program while busy
    c0 = commit_cnt;
    txn(8'h01, 1, 8'hFF);
    chk("R4", "status write commit count", commit_cnt - c0, 1);
    chk("R4", "status write commit op", int'(last_op), 8'h01);
    txn(8'h06, 0, 8'h00);
    txn(8'h02, 3, 8'h00);
    chk("R3", "program while busy rejected", commit_cnt - c0, 1);
    rd_status(s);
    chk("R8", "status while busy with data FF", int'(s), 8'h7F);
    begin
      int polls = 0;
      while (s[0] && polls < 40) begin rd_status(s); polls++; end
    end
    chk("R5", "status write busy length", int'((cyc - commit_cyc) >= T_WRSR), 1);
    chk("R8", "status after FF write", int'(s), 8'h7C);

    // R8: data 0x8B keeps only bit 3 of the writable field
    txn(8'h06, 0, 8'h00);
    txn(8'h01, 1, 8'h8B);
    wait_idle(T_WRSR, 8'h08, "status write 8B");

    // R4 R5: every program and erase opcode
    for (int k = 0; k < 6; k++) begin
      txn(8'h06, 0, 8'h00);
      c0 = commit_cnt;
      txn(wops[k], 3, 8'h00);
      chk("R4", "write op commit count", commit_cnt - c0, 1);
      chk("R4", "write op commit opcode", int'(last_op), int'(wops[k]));
      wait_idle(busy_of(wops[k]), 8'h08, "write op");
    end

    // R10: invalid opcodes ignore later bytes
    txn(8'h06, 0, 8'h00);
    c0 = commit_cnt;
    txn(8'h03, 3, 8'h06);
    for (int i = 0; i < 3; i++) chk("R10", "slow read returns zero", int'(rbuf[i]), 0);
    txn(8'hAB, 2, 8'h04);
    for (int i = 0; i < 2; i++) chk("R10", "unknown op returns zero", int'(rbuf[i]), 0);
    chk("R10", "no commit from invalid", commit_cnt - c0, 0);
    rd_status(s);
    chk("R10", "status after invalid", int'(s), 8'h0A);
    txn(8'h04, 0, 8'h00);

    // R7: flag clear
    txn(8'h50, 0, 8'h00);
    txn(8'h70, 2, 8'h00);
    chk("R7", "flag after clear", int'(rbuf[0]), 8'h85);
    chk("R7", "flag after clear repeat", int'(rbuf[1]), 8'h85);

    // R11: aborted partial opcodes
    cs_lo();
    xbits(8'h06, 7, s);
    cs_hi();
    rd_status(s);
    chk("R11", "partial 06 has no effect", int'(s), 8'h08);
    cs_lo();
    xbits(8'hFF, 5, s);
    cs_hi();
    txn(8'h06, 0, 8'h00);
    rd_status(s);
    chk("R11", "alignment after abort", int'(s), 8'h0A);
    chk("R11", "miso idle with cs high", int'(miso), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule